// File: doc/BRIEF.md
# Adaptive Search Pattern Selector

This controller decides, once per macroblock, which motion-search pattern the search engine should run. It bases the choice on the motion vector and the SAD that were found for the block to the left. A small vector leads to a small, dense full search. Larger vectors lead to progressively wider patterns (A3, A2, A1). If the neighbour's SAD is above a programmable limit, its vector is not trusted, and the selector instead steps one pattern coarser than the choice it made last time.

With the pattern it gives the step schedule that the search engine will follow: how many steps, the horizontal and vertical reach of each step, and the spacing between candidate locations. It also gives the cycle budget expected for that macroblock. A `start` strobe samples the inputs. The decision appears one clock later, together with a one-cycle valid flag, and stays on the outputs until the next strobe.

Top module: `sps_selector`

## Requirements
- R1: When `left_valid` is 0 at a strobe, the selected pattern is A1 (code 3), whatever the vector and SAD inputs are.
- R2: When `left_valid` is 1 and `nb_sad` is strictly greater than `sad_limit`, the pattern is one step coarser than `prev_pattern`. The steps are FS(0)→A3(1)→A2(2)→A1(3), and A1 stays at A1. A SAD equal to the limit does not escalate.
- R3: Otherwise, if |dx| ≤ 8 and |dy| ≤ 4, the pattern is the small full search (code 0).
- R4: Otherwise, |dx| ≤ 16 and |dy| ≤ 8 selects A3 (code 1), |dx| ≤ 24 and |dy| ≤ 12 selects A2 (code 2), and any larger vector selects A1 (code 3).
- R5: Each range test needs both components to pass, and it uses magnitudes of two's-complement inputs. Negative components behave like their positive counterparts, and the most negative input value counts as the largest magnitude.
- R6: Code 0 gives one step with reach (10,5) and spacing 1, and steps 1 and 2 read as zero. A3, A2 and A1 give three steps with spacings 4, 2, 1. Their reaches (x,y) are: A3 (16,8),(4,4),(2,2); A2 (24,12),(8,4),(2,2); A1 (48,24),(8,8),(2,2). Step i occupies bits [i*7 +: 7] of `step_rx`/`step_ry` and [i*3 +: 3] of `step_sp`.
- R7: The cycle budget is 275 for code 0, 380 for A3, 357 for A2 and 633 for A1.
- R8: `dec_valid` is high in exactly the cycle that follows a cycle with `start` high, and at no other time.
- R9: While `start` is low, every decision output holds its value, whatever the inputs do.
- R10: During reset, `dec_valid`, `pattern`, `step_count`, the step fields and `cycle_budget` all read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Sample inputs and make a decision |
| left_valid | input | 1 | A left neighbour block exists |
| nb_dx | input | MV_W | Neighbour vector x, two's complement |
| nb_dy | input | MV_W | Neighbour vector y, two's complement |
| nb_sad | input | SAD_W | Neighbour best SAD |
| sad_limit | input | SAD_W | Escalation threshold (typically 256) |
| prev_pattern | input | 2 | Pattern code chosen for the previous block |
| dec_valid | output | 1 | One-cycle flag, decision updated |
| pattern | output | 2 | 0 FS, 1 A3, 2 A2, 3 A1 |
| step_count | output | 2 | Number of search steps |
| step_rx | output | 3*RNG_W | Per-step horizontal reach |
| step_ry | output | 3*RNG_W | Per-step vertical reach |
| step_sp | output | 3*SP_W | Per-step location spacing |
| cycle_budget | output | CYC_W | Expected cycles for the macroblock |

## Verification
The bench sweeps every vector in a window that reaches past each tier edge, for both signs. An off-by-one edge (< where ≤ is needed) or a test that requires only one of the two components to pass would show up as the wrong code along the tier borders. A magnitude that is wrong for negative inputs or for the most negative value would pick a pattern that is too small. The SAD limit is tested at equality and one above it, for every previous code. Here a reversed comparison, a lost saturation at A1, or escalation that ignores the missing-neighbour case would give the wrong code. Changes to the inputs between strobes catch a register that loads without a strobe, and a single strobe checks that the valid flag drops after one cycle.

// File: rtl/sps_pkg.sv
// Shared types for the search pattern selector.
// Pattern codes are ordered fine to coarse; escalation relies on that order.
package sps_pkg;

    typedef enum logic [1:0] {
        PAT_FS = 2'd0,
        PAT_A3 = 2'd1,
        PAT_A2 = 2'd2,
        PAT_A1 = 2'd3
    } pat_e;

    // Next coarser pattern, saturating at the widest one.
    function automatic pat_e coarser(input pat_e p);
        logic [1:0] nxt;
        nxt = p + 2'd1;
        return (p == PAT_A1) ? PAT_A1 : pat_e'(nxt);
    endfunction

endpackage

// File: rtl/sps_range_classify.sv
// Classifies a neighbour vector into a range tier by component magnitude.
// Assumes the tiers are nested (each tier wider than the one before it in both axes).
// A vector is in a tier only when both |dx| and |dy| are within its limits.
module sps_range_classify
    import sps_pkg::*;
#(
    parameter int MV_W      = 8,
    parameter int TIER_X[3] = '{8, 16, 24},
    parameter int TIER_Y[3] = '{4, 8, 12}
) (
    input  logic signed [MV_W-1:0] dx,
    input  logic signed [MV_W-1:0] dy,
    output pat_e                   range_pat
);
    localparam int MAG_W = MV_W + 1;

    logic [MAG_W-1:0] mag_x;
    logic [MAG_W-1:0] mag_y;
    logic [2:0]       in_tier;

    // Magnitudes one bit wider so the most negative value does not wrap.
    always_comb begin
        mag_x = dx[MV_W-1] ? ({1'b0, ~dx} + MAG_W'(1)) : {1'b0, dx};
        mag_y = dy[MV_W-1] ? ({1'b0, ~dy} + MAG_W'(1)) : {1'b0, dy};
    end

    // One membership test per tier, both axes required.
    for (genvar g = 0; g < 3; g++) begin : g_tier
        assign in_tier[g] = (mag_x <= MAG_W'(TIER_X[g])) &&
                            (mag_y <= MAG_W'(TIER_Y[g]));
    end

    // Innermost tier wins.
    always_comb begin
        if (in_tier[0])      range_pat = PAT_FS;
        else if (in_tier[1]) range_pat = PAT_A3;
        else if (in_tier[2]) range_pat = PAT_A2;
        else                 range_pat = PAT_A1;
    end

    // R3: the innermost tier implies the next one (nesting assumption).
    always_comb begin
        if (in_tier[0]) assert (in_tier[1] && in_tier[2]);
    end
endmodule

// File: rtl/sps_escalate.sv
// Applies the neighbour-presence and SAD-trust rules on top of the range tier.
// Assumes prev_pattern carries a code from the same encoding as the output.
module sps_escalate
    import sps_pkg::*;
#(
    parameter int SAD_W = 16
) (
    input  logic             left_valid,
    input  logic [SAD_W-1:0] nb_sad,
    input  logic [SAD_W-1:0] sad_limit,
    input  logic [1:0]       prev_pattern,
    input  pat_e             range_pat,
    output pat_e             choice
);
    // Priority: no neighbour, then untrusted SAD, then vector size.
    always_comb begin
        if (!left_valid)               choice = PAT_A1;
        else if (nb_sad > sad_limit)   choice = coarser(pat_e'(prev_pattern));
        else                           choice = range_pat;
    end
endmodule

// File: rtl/sps_schedule.sv
// Maps a pattern code to its step schedule and cycle budget.
// Step slot g sits at bits [g*W +: W]; unused slots read zero.
module sps_schedule
    import sps_pkg::*;
#(
    parameter int RNG_W      = 7,
    parameter int SP_W       = 3,
    parameter int CYC_W      = 10,
    parameter int FS_RX      = 10,
    parameter int FS_RY      = 5,
    parameter int A3_RX[3]   = '{16, 4, 2},
    parameter int A3_RY[3]   = '{8, 4, 2},
    parameter int A2_RX[3]   = '{24, 8, 2},
    parameter int A2_RY[3]   = '{12, 4, 2},
    parameter int A1_RX[3]   = '{48, 8, 2},
    parameter int A1_RY[3]   = '{24, 8, 2},
    parameter int STEP_SP[3] = '{4, 2, 1},
    parameter int FS_CYC     = 275,
    parameter int A3_CYC     = 380,
    parameter int A2_CYC     = 357,
    parameter int A1_CYC     = 633
) (
    input  pat_e               pat,
    output logic [1:0]         steps,
    output logic [3*RNG_W-1:0] rx,
    output logic [3*RNG_W-1:0] ry,
    output logic [3*SP_W-1:0]  sp,
    output logic [CYC_W-1:0]   budget
);
    // Step count and budget per pattern.
    always_comb begin
        unique case (pat)
            PAT_FS: begin steps = 2'd1; budget = CYC_W'(FS_CYC); end
            PAT_A3: begin steps = 2'd3; budget = CYC_W'(A3_CYC); end
            PAT_A2: begin steps = 2'd3; budget = CYC_W'(A2_CYC); end
            default: begin steps = 2'd3; budget = CYC_W'(A1_CYC); end
        endcase
    end

    // One slot per step: reach and spacing.
    for (genvar g = 0; g < 3; g++) begin : g_step
        logic [RNG_W-1:0] rx_g;
        logic [RNG_W-1:0] ry_g;
        logic [SP_W-1:0]  sp_g;

        // Slot contents for the chosen pattern.
        always_comb begin
            unique case (pat)
                PAT_FS: begin
                    rx_g = (g == 0) ? RNG_W'(FS_RX) : '0;
                    ry_g = (g == 0) ? RNG_W'(FS_RY) : '0;
                    sp_g = (g == 0) ? SP_W'(STEP_SP[2]) : '0;
                end
                PAT_A3: begin
                    rx_g = RNG_W'(A3_RX[g]);
                    ry_g = RNG_W'(A3_RY[g]);
                    sp_g = SP_W'(STEP_SP[g]);
                end
                PAT_A2: begin
                    rx_g = RNG_W'(A2_RX[g]);
                    ry_g = RNG_W'(A2_RY[g]);
                    sp_g = SP_W'(STEP_SP[g]);
                end
                default: begin
                    rx_g = RNG_W'(A1_RX[g]);
                    ry_g = RNG_W'(A1_RY[g]);
                    sp_g = SP_W'(STEP_SP[g]);
                end
            endcase
        end

        assign rx[g*RNG_W +: RNG_W] = rx_g;
        assign ry[g*RNG_W +: RNG_W] = ry_g;
        assign sp[g*SP_W  +: SP_W]  = sp_g;
    end
endmodule

// File: rtl/sps_selector.sv
// Top of the adaptive search pattern selector.
// Samples the neighbour data on start, registers the decision and schedule,
// and raises dec_valid for the one following cycle. Outputs hold between strobes.
// Assumes a synchronous active-low reset.
module sps_selector
    import sps_pkg::*;
#(
    parameter int MV_W  = 8,
    parameter int SAD_W = 16,
    parameter int RNG_W = 7,
    parameter int SP_W  = 3,
    parameter int CYC_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     left_valid,
    input  logic signed [MV_W-1:0]   nb_dx,
    input  logic signed [MV_W-1:0]   nb_dy,
    input  logic [SAD_W-1:0]         nb_sad,
    input  logic [SAD_W-1:0]         sad_limit,
    input  logic [1:0]               prev_pattern,
    output logic                     dec_valid,
    output logic [1:0]               pattern,
    output logic [1:0]               step_count,
    output logic [3*RNG_W-1:0]       step_rx,
    output logic [3*RNG_W-1:0]       step_ry,
    output logic [3*SP_W-1:0]        step_sp,
    output logic [CYC_W-1:0]         cycle_budget
);
    pat_e               range_pat;
    pat_e               choice;
    logic [1:0]         nx_steps;
    logic [3*RNG_W-1:0] nx_rx;
    logic [3*RNG_W-1:0] nx_ry;
    logic [3*SP_W-1:0]  nx_sp;
    logic [CYC_W-1:0]   nx_budget;

    sps_range_classify #(.MV_W(MV_W)) u_classify (
        .dx        (nb_dx),
        .dy        (nb_dy),
        .range_pat (range_pat)
    );

    sps_escalate #(.SAD_W(SAD_W)) u_escalate (
        .left_valid   (left_valid),
        .nb_sad       (nb_sad),
        .sad_limit    (sad_limit),
        .prev_pattern (prev_pattern),
        .range_pat    (range_pat),
        .choice       (choice)
    );

    sps_schedule #(.RNG_W(RNG_W), .SP_W(SP_W), .CYC_W(CYC_W)) u_schedule (
        .pat    (choice),
        .steps  (nx_steps),
        .rx     (nx_rx),
        .ry     (nx_ry),
        .sp     (nx_sp),
        .budget (nx_budget)
    );

    // Decision register: loads on start, pulses valid once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid    <= 1'b0;
            pattern      <= 2'd0;
            step_count   <= 2'd0;
            step_rx      <= '0;
            step_ry      <= '0;
            step_sp      <= '0;
            cycle_budget <= '0;
        end else begin
            dec_valid <= start;
            if (start) begin
                pattern      <= choice;
                step_count   <= nx_steps;
                step_rx      <= nx_rx;
                step_ry      <= nx_ry;
                step_sp      <= nx_sp;
                cycle_budget <= nx_budget;
            end
        end
    end

    // R8: a strobe yields valid on the next cycle.
    p_valid_after_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> dec_valid);

    // R8: no strobe, no valid.
    p_no_spurious_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !dec_valid);

    // R1: missing neighbour forces the widest pattern.
    p_no_left_widest_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !left_valid) |=> (pattern == 2'd3));

    // R2: an untrusted SAD never lands finer than the previous pattern.
    p_escalate_coarser_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && left_valid && (nb_sad > sad_limit)) |=>
            ((pattern > $past(prev_pattern)) || (pattern == 2'd3)));

    // R9: outputs hold without a strobe.
    p_hold_between_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(pattern) && $stable(cycle_budget) && $stable(step_rx)));

    // R6: the small full search is a single step.
    p_fs_one_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && pattern == 2'd0) |-> (step_count == 2'd1));
endmodule

// File: tb/sps_selector_bench.sv
// Self-checking bench: sweeps the vector window, the SAD limit edge,
// every previous code, reset values and hold behaviour.
module sps_selector_bench;
    localparam int CLK_P = 10;
    localparam int MV_W  = 8;
    localparam int SAD_W = 16;
    localparam int RNG_W = 7;
    localparam int SP_W  = 3;
    localparam int CYC_W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic left_valid = 1'b0;
    logic signed [MV_W-1:0] nb_dx = '0;
    logic signed [MV_W-1:0] nb_dy = '0;
    logic [SAD_W-1:0] nb_sad = '0;
    logic [SAD_W-1:0] sad_limit = 16'd256;
    logic [1:0] prev_pattern = 2'd0;
    logic dec_valid;
    logic [1:0] pattern;
    logic [1:0] step_count;
    logic [3*RNG_W-1:0] step_rx;
    logic [3*RNG_W-1:0] step_ry;
    logic [3*SP_W-1:0] step_sp;
    logic [CYC_W-1:0] cycle_budget;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    sps_selector u_sps_selector (
        .clk(clk), .rst_n(rst_n), .start(start), .left_valid(left_valid),
        .nb_dx(nb_dx), .nb_dy(nb_dy), .nb_sad(nb_sad), .sad_limit(sad_limit),
        .prev_pattern(prev_pattern), .dec_valid(dec_valid), .pattern(pattern),
        .step_count(step_count), .step_rx(step_rx), .step_ry(step_ry),
        .step_sp(step_sp), .cycle_budget(cycle_budget)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Expected code from R1..R5.
    function automatic int exp_pat(input bit lv, input int dx, input int dy,
                                   input int sad, input int lim, input int prev);
        int ax = iabs(dx);
        int ay = iabs(dy);
        if (!lv) return 3;
        if (sad > lim) return (prev == 3) ? 3 : prev + 1;
        if (ax <= 8 && ay <= 4) return 0;
        if (ax <= 16 && ay <= 8) return 1;
        if (ax <= 24 && ay <= 12) return 2;
        return 3;
    endfunction

    // Expected schedule fields from R6 and R7.
    function automatic int exp_rx(input int p, input int i);
        int t3[3] = '{16, 4, 2};
        int t2[3] = '{24, 8, 2};
        int t1[3] = '{48, 8, 2};
        if (p == 0) return (i == 0) ? 10 : 0;
        if (p == 1) return t3[i];
        if (p == 2) return t2[i];
        return t1[i];
    endfunction

    function automatic int exp_ry(input int p, input int i);
        int t3[3] = '{8, 4, 2};
        int t2[3] = '{12, 4, 2};
        int t1[3] = '{24, 8, 2};
        if (p == 0) return (i == 0) ? 5 : 0;
        if (p == 1) return t3[i];
        if (p == 2) return t2[i];
        return t1[i];
    endfunction

    function automatic int exp_sp(input int p, input int i);
        int s[3] = '{4, 2, 1};
        if (p == 0) return (i == 0) ? 1 : 0;
        return s[i];
    endfunction

    function automatic int exp_budget(input int p);
        int b[4] = '{275, 380, 357, 633};
        return b[p];
    endfunction

    // Check all schedule outputs against code p (R6, R7).
    task automatic chk_schedule(input int p);
        bit ok = 1'b1;
        ok &= (int'(step_count) == ((p == 0) ? 1 : 3));
        for (int i = 0; i < 3; i++) begin
            ok &= (int'(step_rx[i*RNG_W +: RNG_W]) == exp_rx(p, i));
            ok &= (int'(step_ry[i*RNG_W +: RNG_W]) == exp_ry(p, i));
            ok &= (int'(step_sp[i*SP_W +: SP_W]) == exp_sp(p, i));
        end
        chk(ok, "R6 schedule", int'(step_rx[RNG_W-1:0]), exp_rx(p, 0));
        chk(int'(cycle_budget) == exp_budget(p), "R7 budget",
            int'(cycle_budget), exp_budget(p));
    endtask

    // One strobe; sample one negedge later, after the registering edge.
    task automatic decide(input bit lv, input int dx, input int dy, input int sad,
                          input int lim, input int prev, input string req);
        int e;
        @(negedge clk);
        left_valid = lv;
        nb_dx = MV_W'(dx);
        nb_dy = MV_W'(dy);
        nb_sad = SAD_W'(sad);
        sad_limit = SAD_W'(lim);
        prev_pattern = 2'(prev);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        e = exp_pat(lv, dx, dy, sad, lim, prev);
        chk(dec_valid && int'(pattern) == e, req, int'(pattern), e);
    endtask

    initial begin
        // R10: reset state.
        repeat (3) @(negedge clk);
        chk(dec_valid == 1'b0 && pattern == 2'd0 && step_count == 2'd0,
            "R10 reset ctrl", int'(pattern), 0);
        chk(step_rx == '0 && step_ry == '0 && step_sp == '0 && cycle_budget == '0,
            "R10 reset fields", int'(cycle_budget), 0);
        rst_n = 1'b1;

        // R3, R4, R5: sweep across every tier edge, both signs.
        for (int dx = -27; dx <= 27; dx++) begin
            for (int dy = -14; dy <= 14; dy++) begin
                decide(1'b1, dx, dy, 100, 256, 0, "R4 sweep");
            end
        end

        // R3 edges: corner in, one past in x only, one past in y only.
        decide(1'b1, -8, -4, 0, 256, 2, "R3 corner");
        chk_schedule(0);
        decide(1'b1, 8, 5, 0, 256, 2, "R5 both axes y");
        chk_schedule(1);
        decide(1'b1, 9, 0, 0, 256, 2, "R5 both axes x");
        decide(1'b1, 16, -8, 0, 256, 0, "R4 A3 edge");
        decide(1'b1, -24, 12, 0, 256, 0, "R4 A2 edge");
        chk_schedule(2);
        decide(1'b1, 0, 13, 0, 256, 0, "R4 A1 beyond");
        chk_schedule(3);
        // R5: most negative value is the largest magnitude.
        decide(1'b1, -128, 0, 0, 256, 0, "R5 min x");
        decide(1'b1, 0, -128, 0, 256, 0, "R5 min y");
        decide(1'b1, 127, 127, 0, 256, 0, "R5 max");

        // R2: limit edge for every previous code, small vector.
        for (int p = 0; p < 4; p++) begin
            decide(1'b1, 1, 1, 256, 256, p, "R2 equal no escalate");
            decide(1'b1, 1, 1, 257, 256, p, "R2 escalate");
            chk_schedule(exp_pat(1'b1, 1, 1, 257, 256, p));
            decide(1'b1, 30, 20, 65535, 0, p, "R2 escalate max sad");
        end

        // R1: no neighbour overrides small vector and high SAD.
        for (int p = 0; p < 4; p++) begin
            decide(1'b0, 0, 0, 0, 256, p, "R1 no left low sad");
            decide(1'b0, 2, 1, 9999, 256, p, "R1 no left high sad");
        end
        chk_schedule(3);

        // R8 and R9: valid drops, outputs hold while inputs move.
        decide(1'b1, 3, 2, 10, 256, 0, "R8 base");
        for (int k = 0; k < 4; k++) begin
            left_valid = k[0];
            nb_dx = MV_W'(40 + k);
            nb_dy = MV_W'(-30);
            nb_sad = 16'd5000;
            prev_pattern = 2'd1;
            @(negedge clk);
            chk(dec_valid == 1'b0, "R8 valid drops", int'(dec_valid), 0);
            chk(pattern == 2'd0, "R9 hold pattern", int'(pattern), 0);
            chk_schedule(0);
        end

        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                #(CLK_P * 200000);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule